// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block follows every instruction through the four pipeline latches that sit behind fetch (decode, execute, memory, write-back) and gives each one a small fault vector. Fetch, decode, execute and memory each have their own fault inputs. A pulse on one of them sets a bit in the vector of the instruction that holds that stage in that cycle. Write-back never posts a fault.

An instruction with any bit set in its vector loses its right to write. Its store is blocked at the memory stage and its register write-back is blocked at the last stage. Faults are acted on only when the instruction holds the write-back latch, so the oldest instruction always traps first, whatever the order in which the faults were raised.

On a trap the block does four things. It raises a one-cycle redirect request that starts the handler fetch on the next cycle. It reports a cause code. It clears every latch and drops the instruction offered at fetch. It saves the faulting PC together with the PCs of the instructions that follow it in delay slots.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset every latch is empty. `trap_req_o`, `trap_cause_o`, `flush_o`, `epc_o`, `rf_we_en_o` and `mem_we_en_o` are all zero.
- R2: A fault pulse sets one bit of the vector of the instruction that holds that stage. `if_fault_i[0..2]` set bits 0..2, `id_fault_i` sets bit 3, `ex_fault_i` sets bit 4, and `mem_fault_i[0..2]` set bits 5..7. An instruction offered at fetch on cycle t holds write-back from edge t+4 onward.
- R3: While a faulted instruction holds write-back, `trap_req_o` is 1 and `trap_cause_o` gives the index of the lowest set bit of its vector. Fetch faults come first, then decode, then execute, then memory. Without a trap the cause output is 0.
- R4: `mem_we_en_o` is 1 only when the memory stage holds a valid instruction, that instruction has an empty vector (this cycle's memory fault inputs included), and no trap is being taken in the same cycle.
- R5: `rf_we_en_o` is 1 exactly when write-back holds a valid instruction with an empty vector.
- R6: An older faulted instruction traps first, even when a younger one posted its fault earlier in time. The younger instruction never traps afterwards.
- R7: In the trap cycle, the fetch input is dropped and all four latches are empty after the next edge. `flush_o` bit 0 marks a valid fetch input, and bits 1, 2 and 3 mark valid instructions in decode, execute and memory.
- R8: `trap_req_o` lasts exactly one cycle per faulting instruction and serves as the request to fetch the handler on the next cycle.
- R9: At the trap edge, `epc_o` word 0 takes the write-back PC and word k takes the PC of the k-th younger latch (memory, execute, decode) for k up to DSLOT. Between traps `epc_o` holds its value.
- R10: A fault pulse on a stage that holds no valid instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | An instruction is being fetched this cycle |
| fetch_pc_i | input | PCW | PC of the fetched instruction |
| if_fault_i | input | 3 | Fetch faults: page fault, misaligned, protection |
| id_fault_i | input | 1 | Decode fault: illegal opcode |
| ex_fault_i | input | 1 | Execute fault: arithmetic |
| mem_fault_i | input | 3 | Memory faults: page fault, misaligned, protection |
| mem_we_en_o | output | 1 | Store permitted for the memory-stage instruction |
| rf_we_en_o | output | 1 | Register write permitted for the write-back instruction |
| flush_o | output | 4 | Younger stages squashed: bit0 fetch, bit1 decode, bit2 execute, bit3 memory |
| trap_req_o | output | 1 | Take a trap; fetch the handler next cycle |
| trap_cause_o | output | 3 | Cause index of the trap |
| epc_o | output | (DSLOT+1)*PCW | Saved PCs, word 0 is the faulting instruction |

## Verification
The hardest case to reach is an older instruction that faults late while a younger instruction has already faulted early. When it happens, the store of the younger one must be blocked and an instruction must also be arriving at fetch in the trap cycle. The bench builds this in order. It issues a clean instruction, then a second one with a fetch page fault. It gives the first a memory fault. In the trap cycle it offers a third, faulting fetch. It then checks the cause, the flush pattern, both saved PCs, and that no later trap follows. A single-instruction table walks each cause bit and several multi-bit vectors to check the priority order.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NCAUSE = 8;
    localparam int CW     = 3;

    typedef enum logic [CW-1:0] {
        C_IF_PAGE   = 3'd0,
        C_IF_ALIGN  = 3'd1,
        C_IF_PROT   = 3'd2,
        C_ID_ILLEGAL = 3'd3,
        C_EX_ARITH  = 3'd4,
        C_MEM_PAGE  = 3'd5,
        C_MEM_ALIGN = 3'd6,
        C_MEM_PROT  = 3'd7
    } cause_e;
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec_i,
    output logic [W-1:0] idx_o,
    output logic         any_o
);
    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = i[W-1:0];
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/exc_epc_save.sv
module exc_epc_save #(
    parameter int PCW   = 32,
    parameter int NSAVE = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture_i,
    input  logic [NSAVE-1:0][PCW-1:0]  pcs_i,
    output logic [NSAVE-1:0][PCW-1:0]  epc_o
);
    logic [NSAVE-1:0][PCW-1:0] epc_d, epc_q;

    always_comb begin
        epc_d = epc_q;
        if (capture_i) epc_d = pcs_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) epc_q <= '0;
        else        epc_q <= epc_d;
    end

    assign epc_o = epc_q;
endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl #(
    parameter int PCW   = 32,
    parameter int DSLOT = 1     // delay-slot length, 0..3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_valid_i,
    input  logic [PCW-1:0]                fetch_pc_i,
    input  logic [2:0]                    if_fault_i,
    input  logic                          id_fault_i,
    input  logic                          ex_fault_i,
    input  logic [2:0]                    mem_fault_i,
    output logic                          mem_we_en_o,
    output logic                          rf_we_en_o,
    output logic [3:0]                    flush_o,
    output logic                          trap_req_o,
    output logic [2:0]                    trap_cause_o,
    output logic [(DSLOT+1)*PCW-1:0]      epc_o
);
    import exc_pkg::*;

    localparam int NSTG  = 4;          // latches: 0 decode, 1 execute, 2 memory, 3 write-back
    localparam int NSAVE = DSLOT + 1;
    localparam int L_MEM = NSTG - 2;
    localparam int L_WB  = NSTG - 1;

    typedef struct packed {
        logic              vld;
        logic [PCW-1:0]    pc;
        logic [NCAUSE-1:0] vec;
    } slot_t;

    typedef struct packed {
        slot_t [NSTG-1:0] st;
    } state_t;

    state_t s_d, s_q;

    logic [NCAUSE-1:0]              post_if;
    logic [NSTG-2:0][NCAUSE-1:0]    post_stage;   // posted while leaving latch k
    logic [CW-1:0]                  wb_idx;
    logic                           wb_any;
    logic                           trap;
    logic [PCW-1:0]                 wb_pc;
    logic [NSAVE-1:0][PCW-1:0]      save_pcs;
    logic [NSAVE-1:0][PCW-1:0]      epc_w;

    exc_prio_enc #(.N(NCAUSE), .W(CW)) u_prio (
        .vec_i (s_q.st[L_WB].vec),
        .idx_o (wb_idx),
        .any_o (wb_any)
    );

    assign trap  = s_q.st[L_WB].vld & wb_any;
    assign wb_pc = s_q.st[L_WB].pc;

    // faults are accepted only for a stage holding a valid instruction
    always_comb begin
        post_if       = fetch_valid_i ? {5'b0, if_fault_i} : '0;
        post_stage[0] = s_q.st[0].vld ? {4'b0, id_fault_i, 3'b0} : '0;
        post_stage[1] = s_q.st[1].vld ? {3'b0, ex_fault_i, 4'b0} : '0;
        post_stage[2] = s_q.st[2].vld ? {mem_fault_i, 5'b0}      : '0;
    end

    always_comb begin
        s_d = s_q;
        s_d.st[0].vld = fetch_valid_i;
        s_d.st[0].pc  = fetch_pc_i;
        s_d.st[0].vec = post_if;
        for (int k = 1; k < NSTG; k++) begin
            s_d.st[k]     = s_q.st[k-1];
            s_d.st[k].vec = s_q.st[k-1].vec | post_stage[k-1];
        end
        if (trap) s_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    genvar g;
    generate
        for (g = 0; g < NSAVE; g++) begin : g_save
            assign save_pcs[g] = s_q.st[L_WB-g].pc;
        end
    endgenerate

    exc_epc_save #(.PCW(PCW), .NSAVE(NSAVE)) u_epc (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (trap),
        .pcs_i     (save_pcs),
        .epc_o     (epc_w)
    );

    assign epc_o        = epc_w;
    assign trap_req_o   = trap;
    assign trap_cause_o = trap ? wb_idx : '0;
    assign rf_we_en_o   = s_q.st[L_WB].vld & ~wb_any;
    assign mem_we_en_o  = s_q.st[L_MEM].vld & ~trap
                        & ~|(s_q.st[L_MEM].vec | post_stage[L_MEM]);
    assign flush_o      = trap ? {s_q.st[2].vld, s_q.st[1].vld, s_q.st[0].vld, fetch_valid_i}
                               : 4'b0;
endmodule

// File: rtl/exc_chk.sv
module exc_chk #(
    parameter int PCW   = 32,
    parameter int NSAVE = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   trap_req,
    input logic                   rf_we_en,
    input logic                   mem_we_en,
    input logic [3:0]             flush,
    input logic [NSAVE*PCW-1:0]   epc,
    input logic [PCW-1:0]         wb_pc
);
    // R5
    trap_blocks_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !rf_we_en);

    // R4
    trap_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !mem_we_en);

    // R8
    single_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    // R9
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> epc[PCW-1:0] == $past(wb_pc));

    // R9
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> $stable(epc));

    // R7
    flush_needs_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush) |-> trap_req);
endmodule

bind precise_exc_ctrl exc_chk #(.PCW(PCW), .NSAVE(NSAVE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_req  (trap_req_o),
    .rf_we_en  (rf_we_en_o),
    .mem_we_en (mem_we_en_o),
    .flush     (flush_o),
    .epc       (epc_o),
    .wb_pc     (wb_pc)
);

// File: tb/sim_precise_exc_ctrl.sv
`timescale 1ns/1ps
module sim_precise_exc_ctrl;
    localparam int PCW   = 32;
    localparam int DSLOT = 1;
    localparam int NV    = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid_i = 1'b0;
    logic [PCW-1:0]    fetch_pc_i = '0;
    logic [2:0]        if_fault_i = '0;
    logic              id_fault_i = 1'b0;
    logic              ex_fault_i = 1'b0;
    logic [2:0]        mem_fault_i = '0;
    logic              mem_we_en_o, rf_we_en_o, trap_req_o;
    logic [3:0]        flush_o;
    logic [2:0]        trap_cause_o;
    logic [(DSLOT+1)*PCW-1:0] epc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    precise_exc_ctrl #(.PCW(PCW), .DSLOT(DSLOT)) u0 (.*);

    // {fault vector, PC}: vector bits follow R2
    localparam logic [39:0] VECS [NV] = '{
        {8'h00, 32'h0000_1000}, {8'h01, 32'h0000_1004}, {8'h02, 32'h0000_1008},
        {8'h04, 32'h0000_100C}, {8'h08, 32'h0000_1010}, {8'h10, 32'h0000_1014},
        {8'h20, 32'h0000_1018}, {8'h40, 32'h0000_101C}, {8'h80, 32'h0000_1020},
        {8'h12, 32'h0000_1024}, {8'hA8, 32'h0000_1028}, {8'hC0, 32'h0000_102C}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        fetch_valid_i = 0; fetch_pc_i = '0; if_fault_i = '0;
        id_fault_i = 0; ex_fault_i = 0; mem_fault_i = '0;
    endtask

    function automatic logic [2:0] lowest(input logic [7:0] v);
        lowest = 3'd0;
        for (int i = 7; i >= 0; i--) if (v[i]) lowest = 3'(i);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 trap", trap_req_o, 0);
        chk("R1 cause", trap_cause_o, 0);
        chk("R1 epc", epc_o, 0);
        chk("R1 rf_we", rf_we_en_o, 0);
        chk("R1 mem_we", mem_we_en_o, 0);
        chk("R1 flush", flush_o, 0);

        // table walk: one instruction at a time, faults at their stages (R2, R3, R4, R5, R8, R9)
        for (int n = 0; n < NV; n++) begin
            logic [7:0]     v;
            logic [PCW-1:0] p;
            v = VECS[n][39:32];
            p = VECS[n][31:0];
            tick();
            fetch_valid_i = 1; fetch_pc_i = p; if_fault_i = v[2:0];
            tick(); idle(); id_fault_i = v[3];
            tick(); idle(); ex_fault_i = v[4];
            tick(); idle(); mem_fault_i = v[7:5];
            #1;
            chk("R4 store gate", mem_we_en_o, (v == 0));
            tick(); idle();
            #1;
            chk("R2 trap at write-back", trap_req_o, (v != 0));
            chk("R3 cause", trap_cause_o, (v != 0) ? lowest(v) : 3'd0);
            chk("R5 rf gate", rf_we_en_o, (v == 0));
            tick();
            chk("R8 one-cycle trap", trap_req_o, 0);
            if (v != 0) chk("R9 epc word0", epc_o[PCW-1:0], p);
        end

        // older wins over earlier younger fault (R6, R7, R9, R4)
        tick(); fetch_valid_i = 1; fetch_pc_i = 32'h100;
        tick(); fetch_pc_i = 32'h104; if_fault_i = 3'b001;
        tick(); idle();
        tick(); mem_fault_i = 3'b010;
        #1;
        chk("R4 older store blocked", mem_we_en_o, 0);
        tick(); idle();
        fetch_valid_i = 1; fetch_pc_i = 32'h200; if_fault_i = 3'b100;
        #1;
        chk("R6 older trap", trap_req_o, 1);
        chk("R6 older cause", trap_cause_o, 3'd6);
        chk("R4 younger store blocked by trap", mem_we_en_o, 0);
        chk("R7 flush pattern", flush_o, 4'b1001);
        tick(); idle();
        chk("R9 epc word0", epc_o[PCW-1:0], 32'h100);
        chk("R9 epc word1", epc_o[2*PCW-1:PCW], 32'h104);
        for (int k = 0; k < 5; k++) begin
            chk("R6 younger never traps", trap_req_o, 0);
            tick();
        end
        chk("R7 squashed fetch leaves no write", rf_we_en_o, 0);

        // clean older retires, younger traps after it (R5, R3, R9)
        tick(); fetch_valid_i = 1; fetch_pc_i = 32'h300;
        tick(); fetch_pc_i = 32'h304; if_fault_i = 3'b100;
        tick(); idle();
        tick();
        chk("R4 clean store allowed", mem_we_en_o, 1);
        tick();
        chk("R5 clean retire writes", rf_we_en_o, 1);
        chk("R5 no trap for clean", trap_req_o, 0);
        tick();
        chk("R3 younger cause", trap_cause_o, 3'd2);
        chk("R5 faulted no write", rf_we_en_o, 0);
        tick();
        chk("R9 epc younger", epc_o[PCW-1:0], 32'h304);
        chk("R9 epc held delay word", epc_o[2*PCW-1:PCW], 32'h0);

        // faults on empty stages are ignored (R10)
        idle();
        id_fault_i = 1; ex_fault_i = 1; mem_fault_i = 3'b111;
        for (int k = 0; k < 3; k++) tick();
        chk("R10 no store on bubble", mem_we_en_o, 0);
        idle();
        for (int k = 0; k < 5; k++) begin
            chk("R10 bubble faults ignored", trap_req_o, 0);
            tick();
        end
        chk("R10 epc untouched", epc_o[PCW-1:0], 32'h304);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule